// File: doc/BRIEF.md
# ADC-to-DAC Passthrough Sequencer

This block runs a straight-through sample loop between a two-channel serial ADC and a single-channel serial DAC. Both converters hang off one serial bus with a common clock, one data-out line and one data-in line, plus a separate active-low select for each device. While enabled, the block repeats one sample period after another. Each period has four steps in a fixed order. It pulses a conversion command. It reads both ADC channels back to back. It turns the chosen channel into the DAC's number format. It writes that word to the DAC. A one-cycle strobe then marks the end of the period.

The ADC gives 14-bit two's-complement samples. The DAC takes 12-bit offset binary. The analog front end inverts the signal, so the block also inverts the output word to cancel it. The design is split into a controller FSM and a datapath. The controller issues every control pulse. The datapath holds the shift registers, the sample registers and the bit counter, and it only reports status back.

Top module: `adc_dac_loop`

## Requirements
- R1: While `rst` is high at a clock edge, both selects go high (inactive), `sck`, `conv`, `done` and `mosi` go low, and the sample registers are cleared.
- R2: While `en` is low and no sample period is in progress, `conv` stays low and both selects stay high.
- R3: Each sample period begins with exactly one `conv` pulse, high for 2*SCK_DIV clock cycles. `conv` is never high while either select is low.
- R4: The ADC read holds `adc_cs_n` low for 28 SCK periods. `miso` is sampled at each rising edge of `sck`. Channel 0 comes first and channel 1 second, each as 14 bits with the MSB first.
- R5: `ch_sel` (0 = channel 0, 1 = channel 1) picks the channel sent to the DAC. It is sampled once, when the sample period starts. A change later in that period has no effect until the next period.
- R6: The DAC word is {s[13], ~s[12:2]} for the selected sample s. This is the offset-binary value (sign bit inverted, two LSBs dropped), then bitwise complemented.
- R7: The DAC write holds `dac_cs_n` low for 12 SCK periods and sends the word MSB first. `mosi` changes only after a falling `sck` edge, so it is stable at every rising edge.
- R8: The two selects are never low together. Between the rise of `adc_cs_n` and the fall of `dac_cs_n`, both stay high for at least one SCK period (2*SCK_DIV clock cycles).
- R9: `sck` has a period of 2*SCK_DIV clock cycles during a transfer. It is low whenever both selects are high.
- R10: `done` is a one-cycle pulse that rises on the edge where `dac_cs_n` returns high. After it, the next sample period starts if `en` is high, and the block goes idle otherwise.
- R11: A synchronous reset in the middle of a transfer aborts the transfer and returns the block to idle. The block then runs correct sample periods once enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the sample loop while high |
| ch_sel | input | 1 | ADC channel forwarded to the DAC |
| miso | input | 1 | Serial data from the ADC |
| sck | output | 1 | Shared serial clock, idles low |
| mosi | output | 1 | Serial data to the DAC |
| adc_cs_n | output | 1 | ADC select, active low |
| dac_cs_n | output | 1 | DAC select, active low |
| conv | output | 1 | Conversion command pulse, once per sample |
| done | output | 1 | One-cycle end-of-sample strobe |

## Verification
Two events can land in the same cycle: the end-of-sample strobe, and the enable or channel-select input changing. The bench drops `en` in the very cycle that `done` is high. It then expects the finished word to arrive intact and no further conversion pulse to follow. The bench also flips `ch_sel` while the ADC read of a period is still running. It judges the result from the word captured by its DAC model, which must still come from the channel selected when the period began.

// File: rtl/pt_pkg.sv
package pt_pkg;

    // Converter formats
    localparam int ADC_W   = 14;
    localparam int DAC_W   = 12;
    localparam int N_CH    = 2;
    localparam int FRAME_W = N_CH * ADC_W;
    localparam int DROP_W  = ADC_W - DAC_W;
    localparam int SEL_W   = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int CNT_W   = $clog2(FRAME_W) + 1;

    typedef logic [ADC_W-1:0] adc_sample_t;
    typedef logic [DAC_W-1:0] dac_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_ADC_SHIFT,
        ST_GAP,
        ST_DAC_SHIFT,
        ST_DONE
    } seq_state_t;

    // Controller to datapath strobes
    typedef struct packed {
        logic sel_latch;
        logic cnt_clr;
        logic adc_rise;
        logic adc_fall;
        logic adc_commit;
        logic dac_load;
        logic dac_fall;
    } dp_ctl_t;

    // Datapath to controller status
    typedef struct packed {
        logic adc_last;
        logic dac_last;
    } dp_stat_t;

    // Signed sample -> offset binary (flip sign), truncate, then complement
    // to cancel the inverting analog front end.
    function automatic dac_word_t to_dac_word(adc_sample_t s);
        dac_word_t ofs;
        ofs = {~s[ADC_W-1], s[ADC_W-2:DROP_W]};
        return ~ofs;
    endfunction

endpackage

// File: rtl/pt_tick_gen.sv
module pt_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
    import pt_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     en,
    input  dp_stat_t stat,
    output dp_ctl_t  ctl,
    output logic     sck,
    output logic     adc_cs_n,
    output logic     dac_cs_n,
    output logic     conv,
    output logic     done
);
    localparam int GAP_MIN = 2 * DIV;
    localparam int GW      = $clog2(GAP_MIN + 1);

    seq_state_t state_q;
    logic       ph_q;
    logic       sck_q;
    logic       adc_cs_q;
    logic       dac_cs_q;
    logic       conv_q;
    logic       done_q;

    // Strobes for the datapath, decoded from the current state on a tick
    always_comb begin
        ctl = '0;
        if (tick) begin
            case (state_q)
                ST_IDLE:      ctl.sel_latch = en;
                ST_CONVERT:   ctl.cnt_clr   = ph_q;
                ST_ADC_SHIFT: begin
                    if (!sck_q) begin
                        ctl.adc_rise = 1'b1;
                    end else begin
                        ctl.adc_fall   = 1'b1;
                        ctl.adc_commit = stat.adc_last;
                    end
                end
                ST_GAP: begin
                    ctl.cnt_clr  = ph_q;
                    ctl.dac_load = ph_q;
                end
                ST_DAC_SHIFT: ctl.dac_fall  = sck_q;
                ST_DONE:      ctl.sel_latch = en;
                default:      ctl = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ph_q     <= 1'b0;
            sck_q    <= 1'b0;
            adc_cs_q <= 1'b1;
            dac_cs_q <= 1'b1;
            conv_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tick) begin
                case (state_q)
                    ST_IDLE: begin
                        if (en) begin
                            state_q <= ST_CONVERT;
                            ph_q    <= 1'b0;
                            conv_q  <= 1'b1;
                        end
                    end
                    ST_CONVERT: begin
                        if (!ph_q) begin
                            ph_q <= 1'b1;
                        end else begin
                            ph_q     <= 1'b0;
                            conv_q   <= 1'b0;
                            adc_cs_q <= 1'b0;
                            state_q  <= ST_ADC_SHIFT;
                        end
                    end
                    ST_ADC_SHIFT: begin
                        if (!sck_q) begin
                            sck_q <= 1'b1;
                        end else begin
                            sck_q <= 1'b0;
                            if (stat.adc_last) begin
                                adc_cs_q <= 1'b1;
                                state_q  <= ST_GAP;
                            end
                        end
                    end
                    ST_GAP: begin
                        if (!ph_q) begin
                            ph_q <= 1'b1;
                        end else begin
                            ph_q     <= 1'b0;
                            dac_cs_q <= 1'b0;
                            state_q  <= ST_DAC_SHIFT;
                        end
                    end
                    ST_DAC_SHIFT: begin
                        if (!sck_q) begin
                            sck_q <= 1'b1;
                        end else begin
                            sck_q <= 1'b0;
                            if (stat.dac_last) begin
                                dac_cs_q <= 1'b1;
                                done_q   <= 1'b1;
                                state_q  <= ST_DONE;
                            end
                        end
                    end
                    ST_DONE: begin
                        if (en) begin
                            state_q <= ST_CONVERT;
                            ph_q    <= 1'b0;
                            conv_q  <= 1'b1;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign sck      = sck_q;
    assign adc_cs_n = adc_cs_q;
    assign dac_cs_n = dac_cs_q;
    assign conv     = conv_q;
    assign done     = done_q;

    // Cycles with both selects idle, saturating at the required gap
    logic [GW-1:0] gap_cnt_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt_q <= '0;
        end else if (!adc_cs_q || !dac_cs_q) begin
            gap_cnt_q <= '0;
        end else if (gap_cnt_q != GW'(GAP_MIN)) begin
            gap_cnt_q <= gap_cnt_q + 1'b1;
        end
    end

    a_r8_one_select: assert property (@(posedge clk) disable iff (rst)
        !(!adc_cs_q && !dac_cs_q));

    a_r8_bus_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_cs_q) |-> gap_cnt_q >= GW'(GAP_MIN));

    a_r9_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
        (adc_cs_q && dac_cs_q) |-> !sck_q);

    a_r3_conv_bus_free: assert property (@(posedge clk) disable iff (rst)
        conv_q |-> (adc_cs_q && dac_cs_q));

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    a_r10_done_at_release: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $rose(dac_cs_q));

endmodule

// File: rtl/pt_datapath.sv
module pt_datapath
    import pt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             miso,
    input  dp_ctl_t          ctl,
    output dp_stat_t         stat,
    output logic             mosi
);
    logic [FRAME_W-1:0] frame_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [SEL_W-1:0]   sel_q;
    adc_sample_t        samp_q [N_CH];
    dac_word_t          dac_q;

    // Bit counter shared by the read and the write
    always_ff @(posedge clk) begin
        if (rst || ctl.cnt_clr) begin
            cnt_q <= '0;
        end else if (ctl.adc_fall || ctl.dac_fall) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // ADC frame shifter, MSB first
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
        end else if (ctl.adc_rise) begin
            frame_q <= {frame_q[FRAME_W-2:0], miso};
        end
    end

    // Per-channel sample registers, channel 0 arrives first
    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                samp_q[g] <= '0;
            end else if (ctl.adc_commit) begin
                samp_q[g] <= frame_q[FRAME_W-1-g*ADC_W -: ADC_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (ctl.sel_latch) begin
            sel_q <= sel_i;
        end
    end

    // DAC word shifter, MSB first, advances after each falling edge
    always_ff @(posedge clk) begin
        if (rst) begin
            dac_q <= '0;
        end else if (ctl.dac_load) begin
            dac_q <= to_dac_word(samp_q[sel_q]);
        end else if (ctl.dac_fall) begin
            dac_q <= {dac_q[DAC_W-2:0], 1'b0};
        end
    end

    assign mosi          = dac_q[DAC_W-1];
    assign stat.adc_last = (cnt_q == CNT_W'(FRAME_W - 1));
    assign stat.dac_last = (cnt_q == CNT_W'(DAC_W - 1));

    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        ctl.adc_fall |-> cnt_q <= CNT_W'(FRAME_W - 1));

    a_r7_write_bound: assert property (@(posedge clk) disable iff (rst)
        ctl.dac_fall |-> cnt_q <= CNT_W'(DAC_W - 1));

endmodule

// File: rtl/adc_dac_loop.sv
module adc_dac_loop
    import pt_pkg::*;
#(
    parameter int SCK_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ch_sel,
    input  logic miso,
    output logic sck,
    output logic mosi,
    output logic adc_cs_n,
    output logic dac_cs_n,
    output logic conv,
    output logic done
);
    logic     tick;
    dp_ctl_t  ctl;
    dp_stat_t stat;

    pt_tick_gen #(.DIV(SCK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    pt_ctrl #(.DIV(SCK_DIV)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .en       (en),
        .stat     (stat),
        .ctl      (ctl),
        .sck      (sck),
        .adc_cs_n (adc_cs_n),
        .dac_cs_n (dac_cs_n),
        .conv     (conv),
        .done     (done)
    );

    pt_datapath u_dp (
        .clk   (clk),
        .rst   (rst),
        .sel_i (SEL_W'(ch_sel)),
        .miso  (miso),
        .ctl   (ctl),
        .stat  (stat),
        .mosi  (mosi)
    );

    a_r7_mosi_settled: assert property (@(posedge clk) disable iff (rst)
        ($rose(sck) && !dac_cs_n) |-> $stable(mosi));

endmodule

// File: tb/sim_adc_dac_loop.sv
`timescale 1ns/1ps
module sim_adc_dac_loop;

    localparam int DIV = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic ch_sel = 1'b0;
    logic miso;
    logic sck, mosi, adc_cs_n, dac_cs_n, conv, done;

    always #2.5 clk = ~clk;

    adc_dac_loop #(.SCK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .en(en), .ch_sel(ch_sel), .miso(miso),
        .sck(sck), .mosi(mosi), .adc_cs_n(adc_cs_n), .dac_cs_n(dac_cs_n),
        .conv(conv), .done(done)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---- converter models and bus monitors (all at the falling clock edge) ----
    logic [27:0] adc_load = '0;
    logic [27:0] adc_sr = '0;
    assign miso = adc_sr[27];

    logic [11:0] dac_sr = '0;
    int dac_word = 0, dac_bits = 0, dac_nbits = 0;
    int adc_rises = 0, conv_cnt = 0, conv_w = 0, conv_start = 0;
    int gap = 0, adc_up_cyc = 0, per_bad = 0, last_rise = 0, cyc = 0;
    bit txn_rise = 0;
    logic p_acs = 1, p_dcs = 1, p_sck = 0, p_conv = 0;

    always @(negedge clk) begin
        cyc++;
        if (p_acs && !adc_cs_n) begin
            adc_sr = adc_load;
            adc_rises = 0;
            txn_rise = 0;
        end else if (!adc_cs_n && p_sck && !sck) begin
            adc_sr = adc_sr << 1;
        end
        if (p_dcs && !dac_cs_n) begin
            dac_bits = 0;
            txn_rise = 0;
            gap = cyc - adc_up_cyc;
        end
        if (!p_acs && adc_cs_n) adc_up_cyc = cyc;
        if (!p_sck && sck) begin
            if (!adc_cs_n) adc_rises++;
            if (!dac_cs_n) begin
                dac_sr = {dac_sr[10:0], mosi};
                dac_bits++;
            end
            if (txn_rise && (cyc - last_rise) != 2 * DIV) per_bad++;
            txn_rise = 1;
            last_rise = cyc;
        end
        if (!p_dcs && dac_cs_n) begin
            dac_word = int'(dac_sr);
            dac_nbits = dac_bits;
        end
        if (!p_conv && conv) begin
            conv_cnt++;
            conv_start = cyc;
        end
        if (p_conv && !conv) conv_w = cyc - conv_start;
        p_acs = adc_cs_n; p_dcs = dac_cs_n; p_sck = sck; p_conv = conv;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (done !== 1'b1 && n < 3000) begin
            step();
            n++;
        end
        chk(req, "done seen", int'(done === 1'b1), 1);
    endtask

    task automatic wait_adc_sel(input string req);
        int n = 0;
        while (adc_cs_n !== 1'b0 && n < 3000) begin
            step();
            n++;
        end
        chk(req, "adc select low", int'(adc_cs_n === 1'b0), 1);
    endtask

    // {ch_sel, channel 0, channel 1, expected DAC word}
    localparam logic [40:0] VEC [8] = '{
        {1'b0, 14'h0000, 14'h3FFF, 12'h7FF},
        {1'b1, 14'h0000, 14'h1FFF, 12'h000},
        {1'b0, 14'h2000, 14'h1FFF, 12'hFFF},
        {1'b1, 14'h1234, 14'h3FFF, 12'h800},
        {1'b0, 14'h1234, 14'h2ABC, 12'h372},
        {1'b1, 14'h1234, 14'h2ABC, 12'hD50},
        {1'b0, 14'h0003, 14'h2000, 12'h7FF},
        {1'b1, 14'h0000, 14'h2001, 12'hFFF}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int base;
        int exp_w;
        // R1: reset state
        repeat (4) step();
        chk("R1", "adc_cs_n", int'(adc_cs_n), 1);
        chk("R1", "dac_cs_n", int'(dac_cs_n), 1);
        chk("R1", "sck", int'(sck), 0);
        chk("R1", "conv", int'(conv), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "mosi", int'(mosi), 0);
        rst = 1'b0;

        // R2: idle while disabled
        base = conv_cnt;
        repeat (80) step();
        chk("R2", "conv pulses", conv_cnt - base, 0);
        chk("R2", "adc_cs_n", int'(adc_cs_n), 1);
        chk("R2", "dac_cs_n", int'(dac_cs_n), 1);

        // Table walk with continuous enable
        ch_sel   = VEC[0][40];
        adc_load = VEC[0][39:12];
        base = conv_cnt;
        en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            exp_w = int'(VEC[i][11:0]);
            wait_done("R10");
            if (i < 7) begin
                ch_sel   = VEC[i+1][40];
                adc_load = VEC[i+1][39:12];
            end else begin
                en = 1'b0;   // drop enable in the done cycle (R10)
            end
            step();
            chk("R10", "done width", int'(done), 0);
            chk("R6", "dac word", dac_word, exp_w);
            chk("R7", "dac bits", dac_nbits, 12);
            chk("R4", "adc sck rises", adc_rises, 28);
            chk("R3", "conv per sample", conv_cnt - base, 1);
            chk("R3", "conv width", conv_w, 2 * DIV);
            chk("R8", "gap ok", int'(gap >= 2 * DIV), 1);
            chk("R9", "sck period errors", per_bad, 0);
            base = conv_cnt;
        end

        // R10: enable dropped with done -> idle, no new conversion
        repeat (300) step();
        chk("R10", "conv after stop", conv_cnt - base, 0);
        chk("R10", "adc_cs_n idle", int'(adc_cs_n), 1);
        chk("R9", "sck idle", int'(sck), 0);

        // R5: select change during the read is ignored
        ch_sel   = 1'b0;
        adc_load = {14'h1234, 14'h2ABC};
        en = 1'b1;
        wait_adc_sel("R5");
        ch_sel = 1'b1;
        en = 1'b0;
        wait_done("R5");
        step();
        chk("R5", "word keeps ch0", dac_word, 12'h372);

        // R11: reset in mid read
        repeat (50) step();
        adc_load = {14'h2000, 14'h0000};
        ch_sel = 1'b0;
        en = 1'b1;
        wait_adc_sel("R11");
        repeat (10) step();
        rst = 1'b1;
        en = 1'b0;
        step();
        step();
        chk("R11", "adc_cs_n", int'(adc_cs_n), 1);
        chk("R11", "sck", int'(sck), 0);
        chk("R11", "conv", int'(conv), 0);
        rst = 1'b0;
        base = conv_cnt;
        repeat (60) step();
        chk("R11", "idle after reset", conv_cnt - base, 0);
        en = 1'b1;
        wait_done("R11");
        en = 1'b0;
        step();
        chk("R11", "word after recovery", dac_word, 12'hFFF);
        chk("R11", "bits after recovery", dac_nbits, 12);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule